// File: doc/BRIEF.md
# Repeating serial message transmitter

This block streams a fixed 32-byte message out on one data line, one bit per clock, and starts over at the first byte as soon as the last bit has gone out. The message is a short ASCII phrase held in a constant table. The table slots after the phrase hold 0xFF. Those filler bytes keep the line high between repetitions.

There is no start bit, stop bit, parity or handshake. A listener finds the message by waiting for the first 0 after a long run of 1s. Every text character has a clear top bit, so that 0 is always the most significant bit of the first character.

The only inputs are the clock and a synchronous, active-high reset. Each byte goes out most significant bit first. The output is a register, so it moves only on a rising clock edge.

Top module: `loop_msg_tx`

## Requirements
- R1: The table holds exactly 32 bytes. Slots 0 to 21 hold the ASCII text "keep it high when idle", one character per slot in reading order. Every byte recovered from the line equals its table slot.
- R2: Each byte is sent over 8 consecutive cycles, starting with bit 7 and ending with bit 0. For example 'h' (0x68) is sent as 0,1,1,0,1,0,0,0.
- R3: While `rst` is high at a rising edge, `ser_out` is driven to 1 at that edge.
- R4: The first rising edge with `rst` low drives bit 7 of table slot 0 onto `ser_out`. The next 255 edges follow it without a gap.
- R5: After bit 0 of slot 31, the next edge sends bit 7 of slot 0. The line therefore repeats with a period of exactly 256 cycles and no idle gap.
- R6: Slots 22 to 31 hold 0xFF, so `ser_out` is 1 for the whole 80-cycle filler stretch.
- R7: Every text byte has bit 7 equal to 0. The first 0 after a run of at least eight 1s is therefore always bit 7 of slot 0.
- R8: Raising `rst` in the middle of a byte or message restarts the stream. The next release begins again at bit 7 of slot 0.
- R9: `ser_out` changes only on a rising edge of `clk`. It holds its value for the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every output change follows its rising edge |
| rst | input | 1 | Synchronous active-high reset; returns the stream to slot 0, bit 7 |
| ser_out | output | 1 | Serial data line, MSB first, high while idle |

## Verification
The assertions assume two things: `rst` is sampled cleanly at rising edges, and the clock is the only other input, so after a released reset the counters alone decide every bit. The post-release check also assumes a reset pulse lasts at least one full cycle. The stimulus respects both assumptions by driving `rst` only just after a falling edge. It holds each reset for 1 to 4 whole cycles, drawn from a fixed-seed random source. Between resets it lets the stream run for random lengths, plus directed runs across several full 256-cycle wraps and a reset in the middle of a byte.

// File: rtl/loop_msg_pkg.sv
package loop_msg_pkg;

   // Width of one character slot in the table.
   localparam int CHAR_W = 8;

   // Text placed at the start of the table; remaining slots are filler.
   localparam int TXT_LEN = 22;
   localparam logic [CHAR_W*TXT_LEN-1:0] TXT = "keep it high when idle";

   // Filler value: all ones keeps the line high.
   localparam logic [CHAR_W-1:0] FILL_BYTE = '1;

   // Table content for a slot index; slot 0 is the leftmost character.
   function automatic logic [CHAR_W-1:0] table_byte(input int idx);
      if (idx < TXT_LEN)
         return TXT[CHAR_W*(TXT_LEN-1-idx) +: CHAR_W];
      return FILL_BYTE;
   endfunction

endpackage

// File: rtl/loop_msg_cnt.sv
module loop_msg_cnt #(
   parameter int BITS_PER_BYTE = 8,
   parameter int NUM_BYTES     = 32,
   parameter int BIT_W         = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1,
   parameter int IDX_W         = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [BIT_W-1:0] bit_cnt,
   output logic [IDX_W-1:0] byte_idx
);

   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BITS_PER_BYTE - 1);
   localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NUM_BYTES - 1);

   initial begin
      assert (BITS_PER_BYTE >= 2) else $error("loop_msg_cnt: BITS_PER_BYTE must be at least 2");
      assert (NUM_BYTES >= 2)     else $error("loop_msg_cnt: NUM_BYTES must be at least 2");
   end

   logic             last_bit;
   logic             last_byte;
   logic [BIT_W-1:0] bit_nxt;
   logic [IDX_W-1:0] byte_nxt;

   assign last_bit  = (bit_cnt == LAST_BIT);
   assign last_byte = (byte_idx == LAST_BYTE);

   // Bit counter: a power-of-two byte width wraps by itself.
   generate
      if (BITS_PER_BYTE == (1 << BIT_W)) begin : g_bit_pow2
         assign bit_nxt = bit_cnt + 1'b1;
      end else begin : g_bit_cmp
         assign bit_nxt = last_bit ? '0 : bit_cnt + 1'b1;
      end
   endgenerate

   // Byte index: moves once per byte, with the same wrap variants.
   generate
      if (NUM_BYTES == (1 << IDX_W)) begin : g_idx_pow2
         assign byte_nxt = last_bit ? byte_idx + 1'b1 : byte_idx;
      end else begin : g_idx_cmp
         assign byte_nxt = last_bit ? (last_byte ? '0 : byte_idx + 1'b1) : byte_idx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt  <= '0;
         byte_idx <= '0;
      end else begin
         bit_cnt  <= bit_nxt;
         byte_idx <= byte_nxt;
      end
   end

   // R5
   byte_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_cnt == LAST_BIT && byte_idx == LAST_BYTE) |=> (byte_idx == '0 && bit_cnt == '0));

   // R2
   bit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_cnt != LAST_BIT) |=> ($stable(byte_idx) && bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

// File: rtl/loop_msg_rom.sv
module loop_msg_rom #(
   parameter int NUM_BYTES = 32,
   parameter int IDX_W     = 5
) (
   input  logic [IDX_W-1:0]                    idx,
   output logic [loop_msg_pkg::CHAR_W-1:0]     byte_val
);

   localparam int W = loop_msg_pkg::CHAR_W;

   initial begin
      assert (loop_msg_pkg::TXT_LEN <= NUM_BYTES)
         else $error("loop_msg_rom: text does not fit in NUM_BYTES slots");
      assert ((1 << IDX_W) >= NUM_BYTES)
         else $error("loop_msg_rom: IDX_W too narrow for NUM_BYTES");
   end

   logic [W-1:0] slots [NUM_BYTES];

   // Constant table built from the package function.
   generate
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slot
         assign slots[i] = loop_msg_pkg::table_byte(i);
      end
   endgenerate

   assign byte_val = slots[idx];

endmodule

// File: rtl/loop_msg_bitsel.sv
module loop_msg_bitsel #(
   parameter int BYTE_W    = 8,
   parameter int BIT_W     = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic [BIT_W-1:0]  bit_cnt,
   output logic              ser_out
);

   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

   initial begin
      assert ((1 << BIT_W) >= BYTE_W) else $error("loop_msg_bitsel: BIT_W too narrow");
   end

   logic bit_sel;

   // Bit order variant.
   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_sel = byte_val[TOP_BIT - bit_cnt];
      end else begin : g_lsb
         assign bit_sel = byte_val[bit_cnt];
      end
   endgenerate

   // Registered output: idle high during reset.
   always_ff @(posedge clk) begin
      if (rst) ser_out <= 1'b1;
      else     ser_out <= bit_sel;
   end

endmodule

// File: rtl/loop_msg_tx.sv
module loop_msg_tx #(
   parameter int NUM_BYTES = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic ser_out
);

   localparam int BYTE_W  = loop_msg_pkg::CHAR_W;
   localparam int TXT_LEN = loop_msg_pkg::TXT_LEN;
   localparam int BIT_W   = $clog2(BYTE_W);
   localparam int IDX_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
   localparam logic [BYTE_W-1:0] SLOT0 = loop_msg_pkg::table_byte(0);
   localparam logic FIRST_BIT = MSB_FIRST ? SLOT0[BYTE_W-1] : SLOT0[0];

   logic [BIT_W-1:0]  bit_cnt;
   logic [IDX_W-1:0]  byte_idx;
   logic [BYTE_W-1:0] byte_val;

   loop_msg_cnt #(
      .BITS_PER_BYTE (BYTE_W),
      .NUM_BYTES     (NUM_BYTES),
      .BIT_W         (BIT_W),
      .IDX_W         (IDX_W)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .bit_cnt  (bit_cnt),
      .byte_idx (byte_idx)
   );

   loop_msg_rom #(
      .NUM_BYTES (NUM_BYTES),
      .IDX_W     (IDX_W)
   ) u_rom (
      .idx      (byte_idx),
      .byte_val (byte_val)
   );

   loop_msg_bitsel #(
      .BYTE_W    (BYTE_W),
      .BIT_W     (BIT_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_sel (
      .clk      (clk),
      .rst      (rst),
      .byte_val (byte_val),
      .bit_cnt  (bit_cnt),
      .ser_out  (ser_out)
   );

   // R4 R8
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |=> (ser_out == FIRST_BIT && bit_cnt == BIT_W'(1) && byte_idx == '0));

   // R6
   fill_high_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(byte_idx) >= TXT_LEN) |=> ser_out);

   // R7
   generate
      if (MSB_FIRST) begin : g_msb_chk
         text_msb_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(byte_idx) < TXT_LEN && bit_cnt == '0) |=> !ser_out);
      end
   endgenerate

endmodule

// File: tb/loop_msg_tx_bench.sv
module loop_msg_tx_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_out;

   int checks   = 0;
   int failures = 0;
   int pos      = 0;
   int ones     = 0;
   logic [7:0] acc = '0;
   logic sampled;
   int unsigned seed_v;

   localparam string BENCH_TXT = "keep it high when idle";

   always #4 clk = ~clk;

   loop_msg_tx u_loop_msg_tx (
      .clk     (clk),
      .rst     (rst),
      .ser_out (ser_out)
   );

   function automatic logic [7:0] exp_byte(input int i);
      if (i < BENCH_TXT.len()) return BENCH_TXT[i];
      return 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // One clock: check after the rising edge, then mid-cycle stability.
   task automatic tick();
      int bi;
      logic [7:0] eb;
      logic e;
      @(posedge clk);
      #2;
      sampled = ser_out;
      if (rst) begin
         chk(ser_out === 1'b1, "R3 line high while reset", int'(ser_out), 1);
         pos  = 0;
         ones = 0;
         acc  = '0;
      end else begin
         bi = (pos / 8) % 32;
         eb = exp_byte(bi);
         e  = eb[7 - (pos % 8)];
         if (pos == 0)
            chk(ser_out === e, "R4 R8 first bit after release", int'(ser_out), int'(e));
         else if (bi >= BENCH_TXT.len())
            chk(ser_out === e, "R6 filler bit high", int'(ser_out), int'(e));
         else if (pos % 8 == 0)
            chk(ser_out === e, "R7 text byte top bit", int'(ser_out), int'(e));
         else
            chk(ser_out === e, "R2 bit order msb first", int'(ser_out), int'(e));
         acc = {acc[6:0], ser_out};
         if (ser_out == 1'b0 && ones >= 8)
            chk(pos % 256 == 0, "R7 first zero after filler starts slot 0", pos % 256, 0);
         ones = ser_out ? ones + 1 : 0;
         if (pos % 8 == 7) begin
            if (pos >= 256 && bi == 0)
               chk(acc == eb, "R5 loop restarts at slot 0", int'(acc), int'(eb));
            else
               chk(acc == eb, "R1 recovered byte", int'(acc), int'(eb));
         end
         pos++;
      end
      @(negedge clk);
      #1;
      chk(ser_out === sampled, "R9 stable between rising edges", int'(ser_out), int'(sampled));
   endtask

   initial begin
      seed_v = $urandom(32'd2024);
      rst = 1'b1;
      repeat (3) tick();
      // Directed: long run across several wraps.
      rst = 1'b0;
      repeat (800) tick();
      // Directed: reset in the middle of a byte.
      rst = 1'b1;
      tick();
      rst = 1'b0;
      repeat (43) tick();
      rst = 1'b1;
      repeat (2) tick();
      rst = 1'b0;
      repeat (300) tick();
      // Random reset pulses and run lengths.
      for (int k = 0; k < 10; k++) begin
         rst = 1'b1;
         repeat (1 + ($urandom % 4)) tick();
         rst = 1'b0;
         repeat (50 + ($urandom % 600)) tick();
      end
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      summary();
      $finish;
   end

endmodule